// File: doc/BRIEF.md
# Effective Address Generator

This unit turns a decoded operand specifier into the address that the load/store path should use. The inputs are the mode code, the values read from the register file for the first and second named registers, the program counter (already advanced past the current instruction), a short signed displacement taken from the instruction word, a full-width extension word, and the operand size. It produces either a memory address or, for the register and immediate forms, the operand value itself, together with a flag that says no memory access is needed.

For the post-increment and pre-decrement forms the unit also produces the updated value of the first register and a write enable for it, so the register file can be updated in the same step that the address is issued. All arithmetic wraps modulo 2^32 and nothing flags overflow. The result is registered: a request presented on one clock edge appears on the outputs after that edge.

Top module: `eag_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid`, `direct_op` and `wb_en` are 0.
- R2: A request sampled with `op_valid`=1 on a rising edge yields `res_valid`=1 after that edge; with `op_valid`=0 it yields `res_valid`=0, `direct_op`=0 and `wb_en`=0.
- R3: Mode 0 (register) returns `ra_val` and mode 1 (immediate) returns `ext_word` on `ea_out`, both with `direct_op`=1; every other mode gives `direct_op`=0.
- R4: Mode 2 (absolute) gives `ea_out`=`ext_word`; mode 3 (register indirect) gives `ea_out`=`ra_val`.
- R5: Mode 4 (indexed) gives `ra_val` plus the 10-bit `offset_raw` sign-extended to 32 bits, and does not assert `wb_en`.
- R6: Mode 5 gives `ra_val`+`rb_val`; mode 6 gives `ra_val`+`rb_val`+sign-extended offset.
- R7: Mode 7 (PC-relative) gives `pc_val` plus the sign-extended offset, so a negative offset reaches addresses below `pc_val`.
- R8: Mode 8 (post-increment) gives `ea_out`=`ra_val` and `wb_val`=`ra_val`+step with `wb_en`=1.
- R9: Mode 9 (pre-decrement) gives `ea_out`=`wb_val`=`ra_val`-step with `wb_en`=1.
- R10: The step is 4 when `size_word`=1 and 1 when `size_word`=0.
- R11: All sums and differences wrap modulo 2^32 (e.g. 0xFFFFFFFE post-incremented by a word writes back 0x00000002).
- R12: Codes 10 to 15 are reserved: `ea_out`=0, `direct_op`=0, `wb_en`=0.
- R13: `wb_en` is 1 only for a valid request in mode 8 or 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| ra_val | input | 32 | Value of the first (base/index) register |
| rb_val | input | 32 | Value of the second register |
| pc_val | input | 32 | Program counter, already past the instruction |
| ext_word | input | 32 | Extension word: immediate value or absolute address |
| offset_raw | input | 10 | Signed displacement field |
| size_word | input | 1 | 1 = word operand, 0 = byte operand |
| res_valid | output | 1 | Result valid |
| ea_out | output | 32 | Effective address, or operand value when `direct_op`=1 |
| direct_op | output | 1 | Operand needs no memory access |
| wb_en | output | 1 | Write `wb_val` back to the first register |
| wb_val | output | 32 | Updated first-register value |

## Verification
The address and the register write-back are produced in the same cycle for the two auto modes, and that pairing is where a mistake hides: post-increment must issue the old value while writing back the new one, pre-decrement must issue and write back the same decremented value. The sweep drives both auto modes with both operand sizes over register values that sit next to zero and next to 2^32, so a swapped order, a wrong step or a lost carry shows in one of the two outputs. Each vector is judged by comparing the issued address and the write-back value, and their difference, against arithmetic done in the bench.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        MD_REG    = 4'd0,
        MD_IMM    = 4'd1,
        MD_ABS    = 4'd2,
        MD_IND    = 4'd3,
        MD_IDX    = 4'd4,
        MD_BIDX   = 4'd5,
        MD_BIDXO  = 4'd6,
        MD_REL    = 4'd7,
        MD_POSTI  = 4'd8,
        MD_PRED   = 4'd9
    } eag_mode_e;

    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_RA   = 2'd1,
        SRC_PC   = 2'd2,
        SRC_EXT  = 2'd3
    } eag_src_e;

    typedef struct packed {
        eag_src_e src;      // first addend
        logic     add_rb;   // add second register
        logic     add_ofs;  // add sign-extended displacement
        logic     pre_dec;  // subtract step from the address
        logic     direct;   // operand delivered without memory access
        logic     wb;       // base register write-back
        logic     wb_dec;   // write-back direction: 1 = down
    } eag_ctrl_t;

    localparam eag_ctrl_t CTRL_NONE = '{SRC_ZERO, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    function automatic logic [2:0] step_of(input logic word);
        return word ? 3'd4 : 3'd1;
    endfunction

endpackage

// File: rtl/eag_mode_decode.sv
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [3:0] mode,
    output eag_ctrl_t  ctrl
);
    always_comb begin
        ctrl = CTRL_NONE;
        case (eag_mode_e'(mode))
            MD_REG:   begin ctrl.src = SRC_RA;  ctrl.direct = 1'b1; end
            MD_IMM:   begin ctrl.src = SRC_EXT; ctrl.direct = 1'b1; end
            MD_ABS:   ctrl.src = SRC_EXT;
            MD_IND:   ctrl.src = SRC_RA;
            MD_IDX:   begin ctrl.src = SRC_RA; ctrl.add_ofs = 1'b1; end
            MD_BIDX:  begin ctrl.src = SRC_RA; ctrl.add_rb = 1'b1; end
            MD_BIDXO: begin ctrl.src = SRC_RA; ctrl.add_rb = 1'b1; ctrl.add_ofs = 1'b1; end
            MD_REL:   begin ctrl.src = SRC_PC; ctrl.add_ofs = 1'b1; end
            MD_POSTI: begin ctrl.src = SRC_RA; ctrl.wb = 1'b1; end
            MD_PRED:  begin ctrl.src = SRC_RA; ctrl.pre_dec = 1'b1;
                            ctrl.wb = 1'b1; ctrl.wb_dec = 1'b1; end
            default:  ctrl = CTRL_NONE;
        endcase
    end
endmodule

// File: rtl/eag_offset_ext.sv
module eag_offset_ext #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 10
) (
    input  logic [OFS_W-1:0]  ofs_in,
    output logic [DATA_W-1:0] ofs_out
);
    generate
        if (OFS_W < DATA_W) begin : g_extend
            localparam int PAD_W = DATA_W - OFS_W;
            assign ofs_out = {{PAD_W{ofs_in[OFS_W-1]}}, ofs_in};
        end else begin : g_trunc
            assign ofs_out = ofs_in[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/eag_addr_sum.sv
module eag_addr_sum #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] term_a,
    input  logic [DATA_W-1:0] term_b,
    input  logic [DATA_W-1:0] term_c,
    input  logic [DATA_W-1:0] term_sub,
    output logic [DATA_W-1:0] total
);
    always_comb total = term_a + term_b + term_c - term_sub;
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 10,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] ra_val,
    input  logic [DATA_W-1:0] rb_val,
    input  logic [DATA_W-1:0] pc_val,
    input  logic [DATA_W-1:0] ext_word,
    input  logic [OFS_W-1:0]  offset_raw,
    input  logic              size_word,
    output logic              res_valid,
    output logic [DATA_W-1:0] ea_out,
    output logic              direct_op,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_val
);
    localparam int STEP_W = 3;

    eag_ctrl_t         ctrl;
    logic [DATA_W-1:0] ofs_sx;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] first_term;
    logic [DATA_W-1:0] addr_nxt;
    logic [DATA_W-1:0] wb_nxt;

    eag_mode_decode u_dec (
        .mode (mode[3:0]),
        .ctrl (ctrl)
    );

    eag_offset_ext #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_ext (
        .ofs_in  (offset_raw),
        .ofs_out (ofs_sx)
    );

    assign step = {{(DATA_W-STEP_W){1'b0}}, step_of(size_word)};

    always_comb begin
        case (ctrl.src)
            SRC_RA:  first_term = ra_val;
            SRC_PC:  first_term = pc_val;
            SRC_EXT: first_term = ext_word;
            default: first_term = '0;
        endcase
    end

    eag_addr_sum #(.DATA_W(DATA_W)) u_addr (
        .term_a   (first_term),
        .term_b   (ctrl.add_rb  ? rb_val : '0),
        .term_c   (ctrl.add_ofs ? ofs_sx : '0),
        .term_sub (ctrl.pre_dec ? step   : '0),
        .total    (addr_nxt)
    );

    always_comb wb_nxt = ctrl.wb_dec ? (ra_val - step) : (ra_val + step);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            direct_op <= 1'b0;
            wb_en     <= 1'b0;
            ea_out    <= '0;
            wb_val    <= '0;
        end else begin
            res_valid <= op_valid;
            direct_op <= op_valid & ctrl.direct;
            wb_en     <= op_valid & ctrl.wb;
            if (op_valid) begin
                ea_out <= addr_nxt;
                wb_val <= wb_nxt;
            end
        end
    end
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 10,
    parameter int MODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [MODE_W-1:0] mode,
    input logic [DATA_W-1:0] ra_val,
    input logic [DATA_W-1:0] rb_val,
    input logic [DATA_W-1:0] pc_val,
    input logic [DATA_W-1:0] ext_word,
    input logic [OFS_W-1:0]  offset_raw,
    input logic              size_word,
    input logic              res_valid,
    input logic [DATA_W-1:0] ea_out,
    input logic              direct_op,
    input logic              wb_en,
    input logic [DATA_W-1:0] wb_val
);
    logic [DATA_W-1:0] chk_sx;
    logic [DATA_W-1:0] chk_step;
    assign chk_sx   = DATA_W'($signed(offset_raw));
    assign chk_step = size_word ? DATA_W'(4) : DATA_W'(1);

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !direct_op && !wb_en));

    assert_wb_only_auto_R13: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ($past(op_valid) && ($past(mode) == MODE_W'(8) || $past(mode) == MODE_W'(9))));

    assert_direct_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (mode == MODE_W'(0) || mode == MODE_W'(1))) |=> direct_op);

    assert_index_sum_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == MODE_W'(4)) |=> (ea_out == $past(ra_val) + $past(chk_sx) && !wb_en));

    assert_rel_pc_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == MODE_W'(7)) |=> (ea_out - $past(pc_val) == $past(chk_sx)));

    assert_posti_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == MODE_W'(8)) |=> (wb_en && ea_out == $past(ra_val) && wb_val - ea_out == $past(chk_step)));

    assert_pred_same_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == MODE_W'(9)) |=> (wb_en && ea_out == wb_val && $past(ra_val) - ea_out == $past(chk_step)));

    assert_abs_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == MODE_W'(2)) |=> (ea_out == $past(ext_word) && !direct_op));

    assert_bidx_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == MODE_W'(5)) |=> (ea_out == $past(ra_val) + $past(rb_val)));
endmodule

bind eag_unit eag_unit_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W), .MODE_W(MODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .mode       (mode),
    .ra_val     (ra_val),
    .rb_val     (rb_val),
    .pc_val     (pc_val),
    .ext_word   (ext_word),
    .offset_raw (offset_raw),
    .size_word  (size_word),
    .res_valid  (res_valid),
    .ea_out     (ea_out),
    .direct_op  (direct_op),
    .wb_en      (wb_en),
    .wb_val     (wb_val)
);

// File: tb/eag_unit_test.sv
module eag_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] ra_val = '0, rb_val = '0, pc_val = '0, ext_word = '0;
    logic [9:0]  offset_raw = '0;
    logic        size_word = 1'b0;
    logic        res_valid, direct_op, wb_en;
    logic [31:0] ea_out, wb_val;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eag_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .mode(mode),
        .ra_val(ra_val), .rb_val(rb_val), .pc_val(pc_val), .ext_word(ext_word),
        .offset_raw(offset_raw), .size_word(size_word),
        .res_valid(res_valid), .ea_out(ea_out), .direct_op(direct_op),
        .wb_en(wb_en), .wb_val(wb_val)
    );

    function automatic logic [31:0] pick(input int i);
        case (i % 6)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_1000;
            3: return 32'h7FFF_FFFF;
            4: return 32'hFFFF_FFFE;
            default: return 32'h8000_0003;
        endcase
    endfunction

    function automatic logic [9:0] pick_ofs(input int i);
        case (i % 6)
            0: return 10'h000;
            1: return 10'h001;
            2: return 10'h1FF;   // +511
            3: return 10'h200;   // -512
            4: return 10'h3FF;   // -1
            default: return 10'h3F0; // -16
        endcase
    endfunction

    function automatic string tag_of(input int m);
        case (m)
            0, 1: return "R3";
            2, 3: return "R4";
            4: return "R5";
            5, 6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_one(input int m, input int p, input int q, input logic sz);
        logic [31:0] sx, stp, e_ea, e_wb;
        logic e_dir, e_wben;
        logic [31:0] a, b, pc, ew;
        a  = pick(p);
        b  = pick(p + q + 1);
        pc = pick(q + 2) + 32'd8;
        ew = pick(p + 3) ^ 32'h00A5_0000;
        @(negedge clk);
        op_valid = 1'b1; mode = 4'(m); ra_val = a; rb_val = b; pc_val = pc;
        ext_word = ew; offset_raw = pick_ofs(q); size_word = sz;
        sx  = {{22{offset_raw[9]}}, offset_raw};
        stp = sz ? 32'd4 : 32'd1;   // R10
        e_dir = 1'b0; e_wben = 1'b0; e_wb = 32'h0;
        case (m)
            0: begin e_ea = a;  e_dir = 1'b1; end
            1: begin e_ea = ew; e_dir = 1'b1; end
            2: e_ea = ew;
            3: e_ea = a;
            4: e_ea = a + sx;
            5: e_ea = a + b;
            6: e_ea = a + b + sx;
            7: e_ea = pc + sx;
            8: begin e_ea = a; e_wb = a + stp; e_wben = 1'b1; end
            9: begin e_ea = a - stp; e_wb = a - stp; e_wben = 1'b1; end
            default: e_ea = 32'h0;
        endcase
        @(negedge clk);
        check1(tag_of(m), {31'b0, res_valid}, 32'd1, "res_valid (R2)");
        check1(tag_of(m), {31'b0, direct_op}, {31'b0, e_dir}, "direct_op");
        check1(e_wben ? "R13" : "R13", {31'b0, wb_en}, {31'b0, e_wben}, "wb_en");
        check1(tag_of(m), ea_out, e_ea, "ea_out (R11 wrap)");
        if (e_wben) check1(sz ? "R10" : "R10", wb_val, e_wb, "wb_val");
    endtask

    initial begin
        #50000000;
        $display("FAIL watchdog expired");
        n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        check1("R1", {29'b0, res_valid, direct_op, wb_en}, 32'd0, "flags in reset");
        rst = 1'b0;
        @(negedge clk);
        check1("R1", {29'b0, res_valid, direct_op, wb_en}, 32'd0, "flags after reset");

        for (int m = 0; m < 16; m++)
            for (int p = 0; p < 6; p++)
                for (int q = 0; q < 6; q++)
                    for (int s = 0; s < 2; s++)
                        run_one(m, p, q, s[0]);

        // R11: explicit wrap corner, post-increment word from 0xFFFFFFFE
        @(negedge clk);
        op_valid = 1'b1; mode = 4'd8; ra_val = 32'hFFFF_FFFE; size_word = 1'b1;
        @(negedge clk);
        check1("R11", wb_val, 32'h0000_0002, "post-inc wrap");
        // R11: pre-decrement byte from zero
        mode = 4'd9; ra_val = 32'h0; size_word = 1'b0;
        @(negedge clk);
        check1("R11", ea_out, 32'hFFFF_FFFF, "pre-dec wrap");

        // R2/R13: idle request leaves flags low even with auto mode on the bus
        op_valid = 1'b0; mode = 4'd8;
        @(negedge clk);
        check1("R2", {29'b0, res_valid, direct_op, wb_en}, 32'd0, "idle flags");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule